// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block gathers 32 interrupt request lines into one bank and presents at most two requests to a processor: one on a normal interrupt output and one on a fast interrupt output. Each line is configured on its own: it can be sampled on rising edges or followed as a level, it carries a 5-bit priority, and in a first-level bank it can be routed to the fast output instead of the normal one. Lines are individually masked, and a bank-wide enable can block both outputs at once.

Software reaches the bank through a single-cycle register port. The read path is combinational; a write takes effect at the clock edge on which the write enable is sampled. Each output channel picks the best pending unmasked line and holds that choice until software acknowledges it through the control register. The channel then stays quiet for two cycles before it presents a new choice. A parameter builds the bank as either a first-level bank (fast output available) or a second-level bank. A second-level bank's normal output is wired into one line of a first-level bank. Global line number n lives in bank n>>5 at bit n&31, so serving a line numbered 32 or above takes one acknowledge in each bank.

Register map (byte offsets): 0x00 pending status, 0x04 line mask, 0x08 current winners (read-only), 0x0C control (write-only), 0x10 bank enable, 0x40 + 4*i configuration of line i.

Top module: `intc_bank`

## Requirements
- R1: After reset, the mask register reads all ones, every configuration register and the status register read 0, the enable register reads 1, the winner register reads 0, and both outputs are low.
- R2: Mask bit i = 1 blocks line i. A masked line never raises an output. A line that is masked while it is being presented is withdrawn one cycle after the mask write, and the output falls.
- R3: The configuration register of line i sits at offset 0x40 + 4*i. Bit 0 = 1 routes the line to the fast output. Bit 1 = 1 selects rising-edge sampling and 0 selects level sampling. Bits 6:2 hold the priority. Higher bits read 0.
- R4: An edge line becomes pending on a rising input and stays pending until it is acknowledged or cleared by software. A level line is pending exactly while its input is high.
- R5: Each channel presents the pending line with the smallest priority value, and the lowest line index wins a tie. The winner register (0x08) reports the normal-channel index in bits 4:0 with a valid flag in bit 7, and the fast-channel index in bits 12:8 with a valid flag in bit 15. Index fields read 0 when their channel is idle. The presented index does not change until the channel is acknowledged or the line is withdrawn.
- R6: Lines with bit 0 set are arbitrated only for the fast output. Control bit 0 acknowledges the normal channel and control bit 1 acknowledges the fast channel, so writing 0x3 clears both.
- R7: With FIRST_LEVEL = 0, bit 0 of every configuration register is stored as 0, and the fast output never rises.
- R8: An acknowledge drops the channel output and clears the pending flag of the presented edge line. The output stays low for at least the two following cycles.
- R9: The enable register bit 0 resets to 1, which blocks both outputs. Writing it to 0 lets pending unmasked lines reach the outputs.
- R10: Reading 0x00 returns the pending flags. A write keeps only the edge flags whose write bit is 1, so a 0 bit clears that edge line. A level line's flag keeps following its input.
- R11: When a second-level bank's normal output drives a first-level line, acknowledging only the first level re-raises the first-level output after the gap. Acknowledging the second level as well leaves both outputs low.
- R12: A rising input that is sampled at clock edge k makes the line pending at k. An idle, enabled channel presents that line at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | LINES | Interrupt request inputs |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Combinational read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds two copies of the bank. One uses FIRST_LEVEL = 1 with its line 0 driven by the normal output of a second copy built with FIRST_LEVEL = 0. Both use 32 lines and an 8-bit address. The first-level copy exercises fast-channel routing, the separate acknowledge bits and the two-cycle gap. The second-level copy shows that the fast-route bit is dropped. The pair together brings the two-level acknowledge of a global line number above 31 within reach.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    localparam int LINES_DEF = 32;
    localparam int PRIO_W    = 5;
    localparam int CFG_W     = PRIO_W + 2;

    localparam int OFS_STATUS = 'h00;
    localparam int OFS_MASK   = 'h04;
    localparam int OFS_WIN    = 'h08;
    localparam int OFS_CTRL   = 'h0C;
    localparam int OFS_GEN    = 'h10;
    localparam int OFS_CFG    = 'h40;

    localparam int WIN_IRQ_VLD = 7;
    localparam int WIN_FIQ_POS = 8;
    localparam int WIN_FIQ_VLD = 15;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              edge_mode;
        logic              to_fiq;
    } line_cfg_t;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ACTIVE = 2'd1,
        CH_GAP    = 2'd2
    } ch_state_e;
endpackage

// File: rtl/intc_line.sv
`timescale 1ns/1ps
module intc_line (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic edge_mode,
    input  logic clr,
    output logic pending
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= line_i;
            if (!edge_mode)
                pend_q <= line_i;
            else if (line_i && !prev_q)
                pend_q <= 1'b1;
            else if (clr)
                pend_q <= 1'b0;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter #(
    parameter int LINES  = 32,
    parameter int PRIO_W = 5,
    parameter int IDX_W  = 5
) (
    input  logic [LINES-1:0]             req,
    input  logic [LINES-1:0][PRIO_W-1:0] prio,
    output logic                         valid,
    output logic [IDX_W-1:0]             idx
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < LINES; i++) begin
            if (req[i] && (!valid || prio[i] < best)) begin
                valid = 1'b1;
                best  = prio[i];
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_channel.sv
`timescale 1ns/1ps
module intc_channel
    import intc_pkg::*;
#(
    parameter int LINES = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] req,
    input  logic             cand_valid,
    input  logic [IDX_W-1:0] cand_idx,
    input  logic             ack,
    output logic             active,
    output logic [IDX_W-1:0] idx_q,
    output logic [LINES-1:0] clr
);
    ch_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: if (cand_valid) begin
                    state_q <= CH_ACTIVE;
                    idx_q   <= cand_idx;
                end
                CH_ACTIVE: begin
                    if (ack)
                        state_q <= CH_GAP;
                    else if (!req[idx_q])
                        state_q <= CH_IDLE;
                end
                CH_GAP:  state_q <= CH_IDLE;
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    assign active = (state_q == CH_ACTIVE);

    always_comb begin
        clr = '0;
        if (active && ack)
            clr[idx_q] = 1'b1;
    end
endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank
    import intc_pkg::*;
#(
    parameter int LINES       = intc_pkg::LINES_DEF,
    parameter int ADDR_W      = 8,
    parameter int FIRST_LEVEL = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  line_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int IDX_W = $clog2(LINES);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_WIN    = ADDR_W'(OFS_WIN);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_GEN    = ADDR_W'(OFS_GEN);
    localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(OFS_CFG + 4 * LINES - 4);
    localparam logic [IDX_W-1:0]  CFG_SEL_BASE = IDX_W'(OFS_CFG / 4);

    logic [LINES-1:0] mask_q;
    logic             gen_off_q;
    line_cfg_t        cfg_q [LINES];
    logic [LINES-1:0] pend;

    // Address decode
    logic             cfg_hit;
    logic [IDX_W-1:0] cfg_sel;
    logic             irq_ack, fiq_ack;
    logic [LINES-1:0] sw_clr;

    assign cfg_hit = (bus_addr >= A_CFG_LO) && (bus_addr <= A_CFG_HI) && (bus_addr[1:0] == 2'b00);
    assign cfg_sel = bus_addr[IDX_W+1:2] - CFG_SEL_BASE;
    assign irq_ack = bus_we && (bus_addr == A_CTRL) && bus_wdata[0];
    assign fiq_ack = bus_we && (bus_addr == A_CTRL) && bus_wdata[1];
    assign sw_clr  = (bus_we && bus_addr == A_STATUS) ? ~bus_wdata : '0;

    // Register writes
    line_cfg_t new_cfg;
    always_comb begin
        new_cfg = line_cfg_t'(bus_wdata[CFG_W-1:0]);
        if (FIRST_LEVEL == 0)
            new_cfg.to_fiq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '1;
            gen_off_q <= 1'b1;
            for (int i = 0; i < LINES; i++)
                cfg_q[i] <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_MASK)
                mask_q <= bus_wdata;
            if (bus_addr == A_GEN)
                gen_off_q <= bus_wdata[0];
            if (cfg_hit)
                cfg_q[cfg_sel] <= new_cfg;
        end
    end

    // Per-line sampling
    logic [LINES-1:0] irq_clr, fiq_clr;
    logic [LINES-1:0] fiq_route;
    logic [LINES-1:0][PRIO_W-1:0] prio_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign fiq_route[g] = cfg_q[g].to_fiq;
        assign prio_vec[g]  = cfg_q[g].prio;
        intc_line u_line (
            .clk       (clk),
            .rst       (rst),
            .line_i    (line_i[g]),
            .edge_mode (cfg_q[g].edge_mode),
            .clr       (sw_clr[g] | irq_clr[g] | fiq_clr[g]),
            .pending   (pend[g])
        );
    end

    // Request sets and arbitration
    logic [LINES-1:0] live, irq_req, fiq_req;
    assign live    = pend & ~mask_q & {LINES{~gen_off_q}};
    assign irq_req = live & ~fiq_route;
    assign fiq_req = live & fiq_route;

    logic             irq_cv, irq_act;
    logic [IDX_W-1:0] irq_cidx, irq_idx;
    logic             fiq_act;
    logic [IDX_W-1:0] fiq_idx;

    intc_arbiter #(.LINES(LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb_irq (
        .req (irq_req), .prio (prio_vec), .valid (irq_cv), .idx (irq_cidx)
    );

    intc_channel #(.LINES(LINES), .IDX_W(IDX_W)) u_ch_irq (
        .clk (clk), .rst (rst), .req (irq_req), .cand_valid (irq_cv),
        .cand_idx (irq_cidx), .ack (irq_ack), .active (irq_act),
        .idx_q (irq_idx), .clr (irq_clr)
    );

    if (FIRST_LEVEL != 0) begin : g_fiq
        logic             fiq_cv;
        logic [IDX_W-1:0] fiq_cidx;
        intc_arbiter #(.LINES(LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb_fiq (
            .req (fiq_req), .prio (prio_vec), .valid (fiq_cv), .idx (fiq_cidx)
        );
        intc_channel #(.LINES(LINES), .IDX_W(IDX_W)) u_ch_fiq (
            .clk (clk), .rst (rst), .req (fiq_req), .cand_valid (fiq_cv),
            .cand_idx (fiq_cidx), .ack (fiq_ack), .active (fiq_act),
            .idx_q (fiq_idx), .clr (fiq_clr)
        );
    end else begin : g_nofiq
        assign fiq_act = 1'b0;
        assign fiq_idx = '0;
        assign fiq_clr = '0;
    end

    assign irq_o = irq_act;
    assign fiq_o = fiq_act;

    // Read path
    logic [LINES-1:0] win_word;
    always_comb begin
        win_word = '0;
        if (irq_act) begin
            win_word[IDX_W-1:0]   = irq_idx;
            win_word[WIN_IRQ_VLD] = 1'b1;
        end
        if (fiq_act) begin
            win_word[WIN_FIQ_POS +: IDX_W] = fiq_idx;
            win_word[WIN_FIQ_VLD]          = 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS)    bus_rdata = pend;
        else if (bus_addr == A_MASK) bus_rdata = mask_q;
        else if (bus_addr == A_WIN)  bus_rdata = win_word;
        else if (bus_addr == A_GEN)  bus_rdata = LINES'(gen_off_q);
        else if (cfg_hit)            bus_rdata = LINES'(cfg_q[cfg_sel]);
    end
endmodule

// File: rtl/intc_bank_chk.sv
`timescale 1ns/1ps
module intc_bank_chk #(
    parameter int LINES       = 32,
    parameter int IDX_W       = 5,
    parameter int FIRST_LEVEL = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_o,
    input logic             fiq_o,
    input logic             irq_ack,
    input logic             fiq_ack,
    input logic [LINES-1:0] mask_q,
    input logic [IDX_W-1:0] irq_idx,
    input logic [IDX_W-1:0] fiq_idx
);
    // R1: outputs quiet on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_o && !fiq_o));

    // R2: a held output never belongs to a line masked in the previous cycle
    a_r2_irq_unmasked: assert property (@(posedge clk) disable iff (rst)
        (irq_o && $past(irq_o)) |-> !$past(mask_q[irq_idx]));
    a_r2_fiq_unmasked: assert property (@(posedge clk) disable iff (rst)
        (fiq_o && $past(fiq_o)) |-> !$past(mask_q[fiq_idx]));

    // R5: presented index is held while the output stays high
    a_r5_irq_idx_held: assert property (@(posedge clk) disable iff (rst)
        (irq_o && $past(irq_o)) |-> $stable(irq_idx));

    // R7: second-level bank never raises the fast output
    a_r7_no_fast_l2: assert property (@(posedge clk) disable iff (rst)
        (FIRST_LEVEL == 0) |-> !fiq_o);

    // R8: two quiet cycles after an acknowledge
    a_r8_irq_gap: assert property (@(posedge clk) disable iff (rst)
        (irq_o && irq_ack) |=> (!irq_o ##1 !irq_o));
    a_r8_fiq_gap: assert property (@(posedge clk) disable iff (rst)
        (fiq_o && fiq_ack) |=> (!fiq_o ##1 !fiq_o));
endmodule

bind intc_bank intc_bank_chk #(
    .LINES(LINES), .IDX_W(IDX_W), .FIRST_LEVEL(FIRST_LEVEL)
) u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .fiq_o(fiq_o),
    .irq_ack(irq_ack), .fiq_ack(fiq_ack), .mask_q(mask_q),
    .irq_idx(irq_idx), .fiq_idx(fiq_idx)
);

// File: tb/intc_bank_bench.sv
`timescale 1ns/1ps
module intc_bank_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [31:0] lines1 = '0, lines2 = '0;
    logic [7:0]  a1 = '0, a2 = '0;
    logic        we1 = 1'b0, we2 = 1'b0;
    logic [31:0] wd1 = '0, wd2 = '0;
    logic [31:0] rd1, rd2;
    logic        irq1, fiq1, irq2, fiq2;
    logic [31:0] l1_in;

    assign l1_in = {lines1[31:1], irq2};

    intc_bank #(.LINES(32), .ADDR_W(8), .FIRST_LEVEL(1)) u_intc_bank (
        .clk(clk), .rst(rst), .line_i(l1_in), .bus_addr(a1), .bus_we(we1),
        .bus_wdata(wd1), .bus_rdata(rd1), .irq_o(irq1), .fiq_o(fiq1)
    );

    intc_bank #(.LINES(32), .ADDR_W(8), .FIRST_LEVEL(0)) u_intc_bank_l2 (
        .clk(clk), .rst(rst), .line_i(lines2), .bus_addr(a2), .bus_we(we2),
        .bus_wdata(wd2), .bus_rdata(rd2), .irq_o(irq2), .fiq_o(fiq2)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit l2, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (l2) begin a2 = a; wd2 = d; we2 = 1'b1; end
        else    begin a1 = a; wd1 = d; we1 = 1'b1; end
        @(negedge clk);
        we1 = 1'b0; we2 = 1'b0;
    endtask

    task automatic rd(input bit l2, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        if (l2) a2 = a; else a1 = a;
        #1;
        d = l2 ? rd2 : rd1;
    endtask

    task automatic pulse1(input logic [31:0] m);
        @(negedge clk); lines1 = lines1 | m;
        @(negedge clk); lines1 = lines1 & ~m;
    endtask

    task automatic do_reset();
        lines1 = '0; lines2 = '0; we1 = 0; we2 = 0;
        @(negedge clk); rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic enable_all(input bit l2);
        wr(l2, 8'h10, 32'h0);
        wr(l2, 8'h04, 32'h0);
    endtask

    function automatic logic [7:0] cfg_a(input int line);
        return 8'(8'h40 + 4 * line);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(0, 8'h04, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(0, 8'h00, v); chk("R1 status", v, 0);
        rd(0, cfg_a(5), v); chk("R1 cfg", v, 0);
        rd(0, 8'h10, v); chk("R1 enable", v, 1);
        rd(0, 8'h08, v); chk("R1 winner", v, 0);
        chk("R1 outputs", {irq1, fiq1, irq2, fiq2}, 0);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        do_reset();
        wr(0, cfg_a(7), 32'hFFFF_FFFF);
        rd(0, cfg_a(7), v); chk("R3 cfg l1", v, 32'h7F);
        wr(0, cfg_a(31), 32'h2A);
        rd(0, cfg_a(31), v); chk("R3 cfg last", v, 32'h2A);
        wr(1, cfg_a(7), 32'h7F);
        rd(1, cfg_a(7), v); chk("R7 fast bit dropped", v, 32'h7E);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        do_reset(); enable_all(0);
        wr(0, cfg_a(3), 32'h2);
        pulse1(32'h8);
        chk("R12 not yet", irq1, 0);
        tick(1);
        chk("R12 irq raised", irq1, 1);
        rd(0, 8'h08, v); chk("R5 winner 3", v, 32'h83);
        rd(0, 8'h00, v); chk("R4 edge held", v, 32'h8);
        wr(0, 8'h0C, 32'h1);
        chk("R8 low after ack", irq1, 0);
        tick(3);
        chk("R8 stays low", irq1, 0);
        rd(0, 8'h00, v); chk("R8 edge cleared", v, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        do_reset(); enable_all(0);
        @(negedge clk); lines1[9] = 1'b1;
        tick(2);
        chk("R4 level raise", irq1, 1);
        rd(0, 8'h00, v); chk("R4 level status", v, 32'h200);
        lines1[9] = 1'b0;
        tick(2);
        chk("R4 level withdraw", irq1, 0);
        rd(0, 8'h00, v); chk("R4 level gone", v, 0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        do_reset(); enable_all(0);
        wr(0, cfg_a(4),  32'h2 | (10 << 2));
        wr(0, cfg_a(20), 32'h2 | (3 << 2));
        pulse1((32'h1 << 4) | (32'h1 << 20));
        tick(1);
        rd(0, 8'h08, v); chk("R5 best prio", v, 32'h80 | 20);
        wr(0, 8'h0C, 32'h1);
        chk("R8 gap 1", irq1, 0);
        tick(1);
        chk("R8 gap 2", irq1, 0);
        tick(1);
        chk("R8 next presented", irq1, 1);
        rd(0, 8'h08, v); chk("R5 second winner", v, 32'h84);
    endtask

    task automatic t_tie();
        logic [31:0] v;
        do_reset(); enable_all(0);
        wr(0, cfg_a(6),  32'h2 | (2 << 2));
        wr(0, cfg_a(17), 32'h2 | (2 << 2));
        pulse1((32'h1 << 6) | (32'h1 << 17));
        tick(1);
        rd(0, 8'h08, v); chk("R5 tie low index", v, 32'h86);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        do_reset();
        wr(0, 8'h10, 32'h0);
        wr(0, 8'h04, 32'hFFFF_FFFF);
        @(negedge clk); lines1[11] = 1'b1;
        tick(3);
        chk("R2 masked silent", irq1, 0);
        rd(0, 8'h00, v); chk("R2 masked still pending", v, 32'h800);
        wr(0, 8'h04, ~(32'h1 << 11));
        tick(1);
        chk("R2 unmask raises", irq1, 1);
        wr(0, 8'h04, 32'hFFFF_FFFF);
        tick(1);
        chk("R2 remask withdraws", irq1, 0);
        lines1[11] = 1'b0;
    endtask

    task automatic t_fiq();
        logic [31:0] v;
        do_reset(); enable_all(0);
        wr(0, cfg_a(2), 32'h3);
        wr(0, cfg_a(8), 32'h2);
        pulse1((32'h1 << 2) | (32'h1 << 8));
        tick(1);
        chk("R6 both raised", {irq1, fiq1}, 2'b11);
        rd(0, 8'h08, v); chk("R6 winners", v, 32'h8288);
        wr(0, 8'h0C, 32'h2);
        chk("R6 fast ack only", {irq1, fiq1}, 2'b10);
        pulse1(32'h1 << 2);
        tick(1);
        chk("R6 fast again", fiq1, 1);
        wr(0, 8'h0C, 32'h3);
        tick(2);
        chk("R6 both cleared", {irq1, fiq1}, 2'b00);
        rd(0, 8'h00, v); chk("R6 status clear", v & 32'h104, 0);
    endtask

    task automatic t_gen();
        do_reset();
        wr(0, 8'h04, 32'h0);
        @(negedge clk); lines1[12] = 1'b1;
        tick(3);
        chk("R9 blocked", irq1, 0);
        wr(0, 8'h10, 32'h0);
        tick(1);
        chk("R9 enabled", irq1, 1);
        lines1[12] = 1'b0;
    endtask

    task automatic t_status();
        logic [31:0] v;
        do_reset();
        wr(0, cfg_a(14), 32'h2);
        pulse1(32'h1 << 14);
        rd(0, 8'h00, v); chk("R10 edge pending", v, 32'h4000);
        wr(0, 8'h00, ~(32'h1 << 14));
        rd(0, 8'h00, v); chk("R10 zero clears", v, 0);
        @(negedge clk); lines1[21] = 1'b1;
        tick(1);
        wr(0, 8'h00, 32'h0);
        rd(0, 8'h00, v); chk("R10 level follows", v, 32'h1 << 21);
        lines1[21] = 1'b0;
    endtask

    task automatic t_l2();
        do_reset(); enable_all(1);
        wr(1, cfg_a(5), 32'h3);
        @(negedge clk); lines2[5] = 1'b1;
        @(negedge clk); lines2[5] = 1'b0;
        tick(1);
        chk("R7 l2 normal not fast", {irq2, fiq2}, 2'b10);
    endtask

    task automatic t_cascade();
        logic [31:0] v;
        int gnum = 42;
        do_reset(); enable_all(0); enable_all(1);
        wr(1, cfg_a(gnum & 31), 32'h2);
        @(negedge clk); lines2[gnum & 31] = 1'b1;
        @(negedge clk); lines2[gnum & 31] = 1'b0;
        tick(1);
        chk("R11 l2 raised", irq2, 1);
        tick(2);
        chk("R11 l1 raised", irq1, 1);
        rd(0, 8'h08, v); chk("R11 l1 winner line 0", v, 32'h80);
        rd(1, 8'h08, v); chk("R11 l2 winner", v, 32'h80 | (gnum & 31));
        wr(0, 8'h0C, 32'h1);
        tick(2);
        chk("R11 l1 ack alone re-raises", irq1, 1);
        wr(1, 8'h0C, 32'h1);
        wr(0, 8'h0C, 32'h1);
        tick(3);
        chk("R11 both acked", {irq1, irq2}, 2'b00);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_cfg();
        t_edge();
        t_level();
        t_priority();
        t_tie();
        t_mask();
        t_fiq();
        t_gen();
        t_status();
        t_l2();
        t_cascade();
        summary();
    end

    initial begin
        #(8 * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule